// File: doc/BRIEF.md
# Noise-Tolerant Decision-Boundary Gap Estimator

This block estimates the size of the missing-code region that a pipeline stage leaves at its decision boundary, and it stays accurate when circuit noise blurs the edges of that region. A plain extreme-value estimate takes the largest raw sample seen with the stage decision bit low and the smallest seen with it high. Noise pushes a few samples into the gap, so that estimate comes out too small. This block uses a coarser view. Each fine sample code is grouped into a coarse bin of K = 2^KLOG codes by dropping its low bits. K is chosen wide enough to cover the noise spread.

Work proceeds in blocks marked by a block-end strobe. In the locate block the block tracks the extreme sample on each side of the boundary, and that gives the coarse edge bin on each side. In the count block that follows, it counts the samples that land in each edge bin and in the coarse bin just outside it (further from the boundary). It then treats each edge bin as if it were reshaped to the height of its neighbour with its area unchanged. The resulting width, K·edge/neighbour, places an effective edge with a resolution of 1/K code. The divisions run on slow shift-and-subtract dividers, one per side. The gap, which is the effective upper edge minus the effective lower edge, is rounded to a whole code and reported with a one-cycle done pulse. Locating then starts again.

Top module: `gapref_top`

## Requirements
- R1: After reset `done_o` is 0, `gap_o` is 0 and the block is in the locate phase with cleared extremes (lower extreme 0, upper extreme all ones).
- R2: The coarse bin of a sample is the sample shifted right by KLOG. During the locate block the block keeps the largest sample with `dbit_i`=0 (lower side) and the smallest with `dbit_i`=1 (upper side). Their coarse bins are latched as the edge bins when the block ends.
- R3: The first `blk_end_i` ends the locate block and the next one ends the count block and starts the division. A sample presented in the same cycle as `blk_end_i` is ignored. Samples and strobes that arrive during the division are ignored.
- R4: During the count block a lower-side sample in the lower edge bin increments the lower edge count, and one in the bin one below increments the lower neighbour count. An upper-side sample in the upper edge bin increments the upper edge count, and one in the bin one above increments the upper neighbour count.
- R5: A neighbour bin outside the code range (lower edge bin 0, or upper edge bin all ones) is never counted, so that side falls back under R7.
- R6: With a nonzero neighbour count and fraction bits F = KLOG, with q = floor(edge·K·2^F / neighbour): the effective upper edge is (bin+1)·K·2^F − q and the effective lower edge is bin·K·2^F + q − 2^F.
- R7: When a side's neighbour count is zero, its divider is skipped and its edge is the plain extreme sample from the locate block, scaled by 2^F.
- R8: `gap_o` = floor((upper − lower + 2^(F−1)) / 2^F), which is the difference rounded half up to a whole code. It is given in two's complement on DW+2 bits.
- R9: `done_o` is a one-cycle pulse. It appears CW+2·KLOG+1 cycles after the clock edge that ends the count block if any side divides, and 1 cycle after that edge if neither side divides.
- R10: Each count saturates at 2^CW−1.
- R11: `gap_o` holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | DW | Raw fine sample code |
| dbit_i | input | 1 | Stage decision bit of the sample (1 = upper side) |
| vld_i | input | 1 | Sample valid |
| blk_end_i | input | 1 | Block-end strobe |
| gap_o | output | DW+2 | Signed gap estimate in fine codes |
| done_o | output | 1 | One-cycle pulse when a new estimate is loaded |

## Verification
The assertions check on every cycle several properties that hold at each clock edge. The extremes only move outward between clears. The counts never wrap. Each quotient, once flagged valid, satisfies the division identity against the operands it captured. A zero-count neighbour yields a valid result one cycle after start. The estimate stays stable outside the done pulse. Only the bench scenarios can show that the final number is right, because that depends on values that build up over whole blocks. These cover the bin-edge interpolation and rounding across all boundary positions modulo K, the fallback and range-guard cases, counter saturation, the two latencies, and the samples that must be ignored.

// File: rtl/gapref_pkg.sv
package gapref_pkg;

  typedef enum logic [1:0] {PH_LOC = 2'd0, PH_CNT = 2'd1, PH_DIV = 2'd2} phase_t;

  // Effective upper edge in fixed point (F = kl fraction bits): top of bin minus width.
  function automatic longint efx_upper(longint bin, longint q, int kl);
    return ((bin + 64'sd1) <<< (2 * kl)) - q;
  endfunction

  // Effective lower edge: bottom of bin plus width, minus one code.
  function automatic longint efx_lower(longint bin, longint q, int kl);
    return (bin <<< (2 * kl)) + q - (64'sd1 <<< kl);
  endfunction

  // Round half up to an integer code (arithmetic shift floors).
  function automatic longint round_lsb(longint v, int kl);
    return (v + (64'sd1 <<< (kl - 1))) >>> kl;
  endfunction

endpackage

// File: rtl/gapref_div.sv
module gapref_div #(
  parameter int NW   = 10,
  parameter int DENW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NW-1:0]   num_i,
  input  logic [DENW-1:0] den_i,
  output logic [NW-1:0]   quo_o,
  output logic            vld_o
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DENW-1:0] rem_q, den_q;
  logic [NW-1:0]   sh_q, num_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q, vld_q;

  logic [DENW:0]   trial;
  logic            ge;
  logic [DENW-1:0] rem_nx;

  assign trial  = {rem_q, sh_q[NW-1]};
  assign ge     = trial >= {1'b0, den_q};
  assign rem_nx = ge ? DENW'(trial - {1'b0, den_q}) : trial[DENW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      sh_q   <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      den_q  <= den_i;
      num_q  <= num_i;
      sh_q   <= (den_i == '0) ? '0 : num_i;
      cnt_q  <= CNTW'(NW);
      busy_q <= (den_i != '0);
      vld_q  <= (den_i == '0);
    end else if (busy_q) begin
      rem_q <= rem_nx;
      sh_q  <= {sh_q[NW-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_q <= 1'b0;
        vld_q  <= 1'b1;
      end
    end
  end

  assign quo_o = sh_q;
  assign vld_o = vld_q;

  // R6: a finished quotient satisfies the division identity
  assert_quot_ident_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vld_o) && den_q != '0) |->
      (longint'(quo_o) * longint'(den_q) <= longint'(num_q)) &&
      (longint'(num_q) - longint'(quo_o) * longint'(den_q) < longint'(den_q)));

  // R7: a zero divisor skips the division
  assert_skip_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && den_i == '0) |=> vld_o);

endmodule

// File: rtl/gapref_side.sv
module gapref_side
  import gapref_pkg::*;
#(
  parameter int DW    = 8,
  parameter int KLOG  = 2,
  parameter int CW    = 6,
  parameter bit UPPER = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  phase_t             phase_i,
  input  logic [DW-1:0]      smp_i,
  input  logic               dbit_i,
  input  logic               take_i,
  input  logic               lock_i,
  input  logic               start_i,
  input  logic               clr_i,
  output logic signed [63:0] edge_fx_o,
  output logic               vld_o
);
  localparam int BW = DW - KLOG;
  localparam int NW = CW + 2 * KLOG;
  localparam logic [DW-1:0] EXT_INIT = UPPER ? {DW{1'b1}} : {DW{1'b0}};
  localparam logic [BW-1:0] BIN_END  = UPPER ? {BW{1'b1}} : {BW{1'b0}};
  localparam logic [CW-1:0] CMAX     = {CW{1'b1}};

  logic [DW-1:0] ext_q;
  logic [BW-1:0] bin_q, nbr_bin, sbin;
  logic [CW-1:0] cnt_e_q, cnt_n_q;
  logic          mine, better, nbr_ok, e_hit, n_hit;
  logic [NW-1:0] quo;

  assign mine    = (dbit_i == UPPER);
  assign sbin    = smp_i[DW-1:KLOG];
  assign better  = UPPER ? (smp_i < ext_q) : (smp_i > ext_q);
  assign nbr_ok  = (bin_q != BIN_END);
  assign nbr_bin = UPPER ? bin_q + 1'b1 : bin_q - 1'b1;
  assign e_hit   = (phase_i == PH_CNT) && take_i && mine && (sbin == bin_q);
  assign n_hit   = (phase_i == PH_CNT) && take_i && mine && nbr_ok && (sbin == nbr_bin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= EXT_INIT;
      bin_q   <= '0;
      cnt_e_q <= '0;
      cnt_n_q <= '0;
    end else begin
      if (clr_i)
        ext_q <= EXT_INIT;
      else if (phase_i == PH_LOC && take_i && mine && better)
        ext_q <= smp_i;
      if (lock_i) begin
        bin_q   <= ext_q[DW-1:KLOG];
        cnt_e_q <= '0;
        cnt_n_q <= '0;
      end else begin
        if (e_hit && cnt_e_q != CMAX) cnt_e_q <= cnt_e_q + 1'b1;
        if (n_hit && cnt_n_q != CMAX) cnt_n_q <= cnt_n_q + 1'b1;
      end
    end
  end

  gapref_div #(.NW(NW), .DENW(CW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .num_i   ({cnt_e_q, {(2 * KLOG){1'b0}}}),
    .den_i   (cnt_n_q),
    .quo_o   (quo),
    .vld_o   (vld_o)
  );

  always_comb begin
    if (cnt_n_q == '0)
      edge_fx_o = longint'(ext_q) <<< KLOG;
    else if (UPPER)
      edge_fx_o = efx_upper(longint'(bin_q), longint'(quo), KLOG);
    else
      edge_fx_o = efx_lower(longint'(bin_q), longint'(quo), KLOG);
  end

  // R2: the extreme only moves outward until cleared
  assert_ext_outward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (UPPER ? (ext_q <= $past(ext_q)) : (ext_q >= $past(ext_q))));

  // R10: counts never wrap
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> (cnt_e_q >= $past(cnt_e_q)) && (cnt_n_q >= $past(cnt_n_q)));

  // R5: an out-of-range neighbour bin stays empty
  assert_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_LOC && !nbr_ok) |-> (cnt_n_q == '0));

endmodule

// File: rtl/gapref_top.sv
module gapref_top
  import gapref_pkg::*;
#(
  parameter int DW   = 8,
  parameter int KLOG = 2,
  parameter int CW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        smp_i,
  input  logic                 dbit_i,
  input  logic                 vld_i,
  input  logic                 blk_end_i,
  output logic signed [DW+1:0] gap_o,
  output logic                 done_o
);
  localparam int GW = DW + 2;

  phase_t             ph_q;
  logic               take, lock, start, fin;
  logic signed [63:0] edge_fx [2];
  logic               side_vld [2];
  logic signed [GW-1:0] gap_q;
  logic               done_q;

  assign take  = vld_i && !blk_end_i;
  assign lock  = (ph_q == PH_LOC) && blk_end_i;
  assign start = (ph_q == PH_CNT) && blk_end_i;
  assign fin   = (ph_q == PH_DIV) && side_vld[0] && side_vld[1];

  for (genvar g = 0; g < 2; g++) begin : g_side
    gapref_side #(.DW(DW), .KLOG(KLOG), .CW(CW), .UPPER(g == 1)) u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_i   (ph_q),
      .smp_i     (smp_i),
      .dbit_i    (dbit_i),
      .take_i    (take),
      .lock_i    (lock),
      .start_i   (start),
      .clr_i     (fin),
      .edge_fx_o (edge_fx[g]),
      .vld_o     (side_vld[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_LOC;
      gap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      unique case (ph_q)
        PH_LOC: if (blk_end_i) ph_q <= PH_CNT;
        PH_CNT: if (blk_end_i) ph_q <= PH_DIV;
        default: if (fin) begin
          ph_q  <= PH_LOC;
          gap_q <= GW'(round_lsb(edge_fx[1] - edge_fx[0], KLOG));
        end
      endcase
    end
  end

  assign gap_o  = gap_q;
  assign done_o = done_q;

  // R9: done is a single-cycle pulse following the division phase
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_after_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ph_q == PH_LOC) && ($past(ph_q) == PH_DIV));

  // R11: estimate is stable outside done
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(gap_o));

endmodule

// File: tb/tb_gapref_top.sv
module tb_gapref_top;
  localparam int DW   = 8;
  localparam int KLOG = 2;
  localparam int CW   = 6;
  localparam int K    = 1 << KLOG;
  localparam int FS   = 1 << KLOG;
  localparam int CMX  = (1 << CW) - 1;
  localparam int BMX  = (1 << (DW - KLOG)) - 1;
  localparam int LATD = CW + 2 * KLOG + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] smp = '0;
  logic dbit = 1'b0, vld = 1'b0, blk = 1'b0;
  logic signed [DW+1:0] gap;
  logic done;

  int n_tests = 0, n_fail = 0;
  bit reported = 0;

  // bench model state
  int ph = 0, bmax = 0, bmin = (1 << DW) - 1, blb = 0, bhb = 0;
  int ce_lo = 0, cn_lo = 0, ce_hi = 0, cn_hi = 0;

  always #2.5 clk = ~clk;

  gapref_top #(.DW(DW), .KLOG(KLOG), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .dbit_i(dbit), .vld_i(vld),
    .blk_end_i(blk), .gap_o(gap), .done_o(done));

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v < CMX) ? v + 1 : v;
  endfunction

  task automatic put(int s, bit d);
    @(negedge clk);
    smp = DW'(s); dbit = d; vld = 1'b1; blk = 1'b0;
    if (ph == 0) begin
      if (!d && s > bmax) bmax = s;
      if (d && s < bmin) bmin = s;
    end else begin
      if (!d && (s >> KLOG) == blb) ce_lo = sat(ce_lo);
      if (!d && blb > 0 && (s >> KLOG) == blb - 1) cn_lo = sat(cn_lo);
      if (d && (s >> KLOG) == bhb) ce_hi = sat(ce_hi);
      if (d && bhb < BMX && (s >> KLOG) == bhb + 1) cn_hi = sat(cn_hi);
    end
  endtask

  // end locate block; the sample riding with the strobe is ignored (R3)
  task automatic end_locate(bit with_smp, int s, bit d);
    @(negedge clk);
    smp = DW'(s); dbit = d; vld = with_smp; blk = 1'b1;
    blb = bmax >> KLOG; bhb = bmin >> KLOG;
    ce_lo = 0; cn_lo = 0; ce_hi = 0; cn_hi = 0; ph = 1;
    @(negedge clk);
    vld = 1'b0; blk = 1'b0;
  endtask

  task automatic end_count(bit junk, bit with_smp, int s, string tag);
    int lo_fx, hi_fx, exp_gap, exp_lat, lat, held;
    @(negedge clk);
    smp = DW'(s); dbit = 1'b0; vld = with_smp; blk = 1'b1;
    lo_fx = (cn_lo == 0) ? bmax * FS : blb * K * FS + (ce_lo * K * FS) / cn_lo - FS;
    hi_fx = (cn_hi == 0) ? bmin * FS : (bhb + 1) * K * FS - (ce_hi * K * FS) / cn_hi;
    exp_gap = (hi_fx - lo_fx + FS / 2) >>> KLOG;
    exp_lat = (cn_lo != 0 || cn_hi != 0) ? LATD : 1;
    ph = 0; bmax = 0; bmin = (1 << DW) - 1;
    @(negedge clk);
    blk = 1'b0; vld = junk; smp = 8'hFF; dbit = 1'b0;
    lat = -1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (done) begin lat = k; break; end
      if (junk && k < 4) begin
        smp = DW'(k * 37); dbit = k[0]; blk = k[1]; vld = 1'b1;
      end else begin
        vld = 1'b0; blk = 1'b0;
      end
    end
    vld = 1'b0; blk = 1'b0;
    chk(lat == exp_lat, {"R9 latency ", tag}, lat, exp_lat);
    chk(int'(gap) == exp_gap, {"R2/R4/R6/R7/R8 gap ", tag}, int'(gap), exp_gap);
    held = int'(gap);
    @(negedge clk);
    chk(!done, {"R9 pulse width ", tag}, int'(done), 0);
    repeat (2) @(negedge clk);
    chk(int'(gap) == held && !done, {"R11 hold ", tag}, int'(gap), held);
  endtask

  task automatic run_std(int mlo, int mhi, int nz, bit junk);
    for (int c = mlo - 7; c <= mlo; c++) put(c, 1'b0);
    for (int c = mhi; c <= mhi + 7; c++) put(c, 1'b1);
    end_locate(1'b0, 0, 1'b0);
    for (int c = mlo - 11; c <= mlo; c++)
      for (int r = 0; r < 1 + ((c * 7 + nz) % 3); r++) put(c, 1'b0);
    for (int c = mhi; c <= mhi + 11; c++)
      for (int r = 0; r < 1 + ((c * 5 + nz) % 3); r++) put(c, 1'b1);
    for (int r = 0; r < nz; r++) begin
      put(mlo + 1, 1'b0);
      put(mhi - 1, 1'b1);
    end
    end_count(junk, 1'b0, 0, "R4 std sweep");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(gap == '0, "R1 gap after reset", int'(gap), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty blocks, no divisions: extremes at reset values, latency 1 (R9, R7)
    end_locate(1'b0, 0, 1'b0);
    end_count(1'b0, 1'b0, 0, "R1 empty R7");

    // R2/R4/R6/R8: sweep boundary positions across all residues modulo K
    for (int mlo = 100; mlo < 132; mlo++)
      for (int g = 0; g < 4; g++)
        for (int nz = 0; nz < 3; nz++)
          run_std(mlo, mlo + 1 + 3 * g, nz, 1'b0);

    // R3: samples and strobes during division ignored
    for (int mlo = 60; mlo < 64; mlo++) run_std(mlo, mlo + 5, 1, 1'b1);

    // R3: sample riding the strobe is ignored in both blocks
    for (int c = 110; c <= 121; c++) put(c, 1'b0);
    for (int c = 130; c <= 141; c++) put(c, 1'b1);
    end_locate(1'b1, 250, 1'b0);
    for (int c = 108; c <= 121; c++) put(c, 1'b0);
    for (int c = 130; c <= 143; c++) put(c, 1'b1);
    end_count(1'b0, 1'b1, 121, "R3 strobe sample");

    // R5: empty lower side (edge bin 0) and upper edge at top bin, both fall back
    for (int c = 252; c <= 255; c++) put(c, 1'b1);
    end_locate(1'b0, 0, 1'b0);
    for (int c = 248; c <= 255; c++) put(c, 1'b1);
    put(0, 1'b0); put(1, 1'b0);
    end_count(1'b0, 1'b0, 0, "R5 range guard R7");

    // R7: one side falls back, the other divides
    put(90, 1'b0);
    for (int c = 150; c <= 157; c++) put(c, 1'b1);
    end_locate(1'b0, 0, 1'b0);
    put(90, 1'b0); put(90, 1'b0);
    for (int c = 150; c <= 161; c++) put(c, 1'b1);
    end_count(1'b0, 1'b0, 0, "R7 lower fallback");

    // R10: edge count saturates
    put(100, 1'b0);
    put(161, 1'b1);
    end_locate(1'b0, 0, 1'b0);
    for (int r = 0; r < 70; r++) put(161, 1'b1);
    put(164, 1'b1);
    put(100, 1'b0);
    end_count(1'b0, 1'b0, 0, "R10 saturation");

    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end
endmodule